// File: doc/BRIEF.md
# Five-Bit Bidirectional I/O Port

A small general-purpose I/O peripheral that sits on an 8-bit register bus and controls five tri-state pads. Each pad has one bit of output data and one bit of direction. Software selects one of two registers: the data register or the direction register. It can write a whole byte, set or clear a single bit, or read the register back. The block drives an output value and an output-enable for each pad. It takes the pad input levels through a two-flop synchronizer.

Reads of the data register return the synchronized pad levels, not the stored output data. Every change to the data register is a read-modify-write on those pad levels. Because of this, a single-bit set or clear also copies the current input levels of the other pins into their output latches. Pin 4 can only pull low (open-drain), and its synchronized input level is also exported as a clock tap for a timer outside the block. Unused upper bits always read as zero.

Top module: `gpio5_port`

## Requirements
- R1: After reset the direction register reads 0x1F (all pins inputs), every output-enable is 0, and every output latch holds 0, so pad_out is 0.
- R2: For pins 0 to 3, a direction bit of 0 sets the output-enable to 1 and a direction bit of 1 sets it to 0. pad_out on these pins always equals the latch bit. The output-enables change only in the cycle after a bus operation.
- R3: Pin 4 is open-drain. pad_out[4] is always 0. pad_oe[4] is 1 only when direction bit 4 is 0 and latch bit 4 is 0.
- R4: With reg_sel = 0 (data register), rd_data equals {3'b000, pad_in} as sampled two rising edges earlier.
- R5: With reg_sel = 1 (direction register), rd_data equals {3'b000, direction bits}. Bits 7 to 5 of a written byte are discarded.
- R6: A byte write to the data register loads wr_data[4:0] into the latches at the next edge and leaves the direction register unchanged.
- R7: A byte write to the direction register loads wr_data[4:0] at the next edge and leaves the latches unchanged.
- R8: A bit-set or bit-clear on the data register loads the latches with the synchronized pad levels, with the bit at bit_idx forced to 1 (set) or 0 (clear). For bit_idx 5 to 7, the latches receive the pad levels unchanged.
- R9: A bit-set or bit-clear on the direction register changes only the addressed bit. bit_idx 5 to 7 has no effect, and the latches are untouched.
- R10: When strobes coincide, wr_en takes priority over bit_set, and bit_set takes priority over bit_clr.
- R11: tmr_clk_tap equals pad_in[4] delayed by the same two edges, whatever the direction setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register select: 0 data, 1 direction |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_idx | input | 3 | Bit index for set/clear |
| rd_data | output | 8 | Combinational read data for reg_sel |
| pad_in | input | 5 | Pad input levels |
| pad_out | output | 5 | Pad output values |
| pad_oe | output | 5 | Pad output enables (1 drives) |
| tmr_clk_tap | output | 1 | Synchronized pin-4 level for a timer clock |

## Verification
A corrupted latch shows on pad_out or pad_oe in the cycle after the faulty write. For pin 4 it shows only on pad_oe, and only while that pin is an output. A corrupted direction bit shows at once on the combinational direction read-back and on pad_oe. A synchronizer fault shows as a data read or timer tap that arrives one edge early or late. The bench therefore samples both the first and the second cycle after each pad change. A read-modify-write fault, where the latch value is used instead of the pad levels, is visible only when the pads differ from the latches. The bench sets up that difference before each bit operation.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned GPIO_BUS_W  = 8;
  localparam int unsigned GPIO_PORT_W = 5;
  localparam int unsigned GPIO_OD_BIT = 4;

  // register select encoding on the bus
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= g_stage[s-1].q;
      end
    end
  end

  assign rst_sync_n = g_stage[STAGES-1].q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= g_stage[s-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned PORT_W = 5,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_dir,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_bits,
  input  logic              bit_set,
  input  logic              bit_clr,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [PORT_W-1:0] pins,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q
);
  logic [PORT_W-1:0] mask;
  logic [PORT_W-1:0] latch_d;
  logic [PORT_W-1:0] dir_d;
  logic [PORT_W-1:0] src;
  logic              any_op;
  logic              latch_en;
  logic              dir_en;

  // one-hot of the addressed bit; all zero when the index is past the port
  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      mask[i] = (32'(bit_idx) == i);
    end
  end

  assign any_op   = wr_en | bit_set | bit_clr;
  assign latch_en = any_op & ~sel_dir;
  assign dir_en   = any_op &  sel_dir;

  // data register reads back pins, direction register reads back itself
  assign src = sel_dir ? dir_q : pins;

  always_comb begin
    if (wr_en) begin
      latch_d = wr_bits;
      dir_d   = wr_bits;
    end else if (bit_set) begin
      latch_d = src | mask;
      dir_d   = src | mask;
    end else begin
      latch_d = src & ~mask;
      dir_d   = src & ~mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (dir_en) dir_q <= dir_d;
  end
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int unsigned PORT_W = 5,
  parameter int unsigned OD_BIT = 4
) (
  input  logic [PORT_W-1:0] latch_q,
  input  logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == OD_BIT) begin : g_open_drain
      assign pad_out[i] = 1'b0;
      assign pad_oe[i]  = ~dir_q[i] & ~latch_q[i];
    end else begin : g_push_pull
      assign pad_out[i] = latch_q[i];
      assign pad_oe[i]  = ~dir_q[i];
    end
  end
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port
  import gpio_pkg::*;
#(
  parameter int unsigned BUS_W       = GPIO_BUS_W,
  parameter int unsigned PORT_W      = GPIO_PORT_W,
  parameter int unsigned OD_BIT      = GPIO_OD_BIT,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_sel,
  input  logic                     wr_en,
  input  logic [BUS_W-1:0]         wr_data,
  input  logic                     bit_set,
  input  logic                     bit_clr,
  input  logic [$clog2(BUS_W)-1:0] bit_idx,
  output logic [BUS_W-1:0]         rd_data,
  input  logic [PORT_W-1:0]        pad_in,
  output logic [PORT_W-1:0]        pad_out,
  output logic [PORT_W-1:0]        pad_oe,
  output logic                     tmr_clk_tap
);
  localparam int unsigned IDX_W = $clog2(BUS_W);
  localparam int unsigned PAD_Z = BUS_W - PORT_W;

  logic              rst_int_n;
  logic [PORT_W-1:0] pin_s;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] dir_q;
  logic              sel_dir;
  logic              unused_hi;

  assign sel_dir   = (reg_sel_e'(reg_sel) == SEL_DIR);
  assign unused_hi = ^wr_data[BUS_W-1:PORT_W];

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  gpio_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pad_in),
    .q     (pin_s)
  );

  gpio_port_regs #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel_dir (sel_dir),
    .wr_en   (wr_en),
    .wr_bits (wr_data[PORT_W-1:0]),
    .bit_set (bit_set),
    .bit_clr (bit_clr),
    .bit_idx (bit_idx),
    .pins    (pin_s),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  gpio_pad_drv #(.PORT_W(PORT_W), .OD_BIT(OD_BIT)) u_pad (
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  always_comb begin
    if (sel_dir) rd_data = {{PAD_Z{1'b0}}, dir_q};
    else         rd_data = {{PAD_Z{1'b0}}, pin_s};
  end

  assign tmr_clk_tap = pin_s[OD_BIT];
endmodule

// File: rtl/gpio5_port_chk.sv
module gpio5_port_chk #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned PORT_W = 5,
  parameter int unsigned OD_BIT = 4,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              reg_sel,
  input logic              wr_en,
  input logic [BUS_W-1:0]  wr_data,
  input logic              bit_set,
  input logic              bit_clr,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [BUS_W-1:0]  rd_data,
  input logic [PORT_W-1:0] pad_in,
  input logic [PORT_W-1:0] pad_oe,
  input logic              tmr_clk_tap,
  input logic [PORT_W-1:0] latch,
  input logic [PORT_W-1:0] dir
);
  logic [1:0]        age;
  logic [PORT_W-1:0] idx_mask;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)      age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    for (int i = 0; i < PORT_W; i++) idx_mask[i] = (32'(bit_idx) == i);
  end

  // R4
  rd_pins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age >= 2'd2 && !reg_sel) |-> rd_data[PORT_W-1:0] == $past(pad_in, 2));

  // R11
  tmr_tap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age >= 2'd2) |-> tmr_clk_tap == $past(pad_in[OD_BIT], 2));

  // R6 R10
  latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !reg_sel) |=> (latch == $past(wr_data[PORT_W-1:0])) && $stable(dir));

  // R7
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && reg_sel) |=> (dir == $past(wr_data[PORT_W-1:0])) && $stable(latch));

  // R8
  latch_bset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_en && bit_set && !reg_sel) |=>
      latch == ($past(rd_data[PORT_W-1:0]) | $past(idx_mask)));

  // R9
  dir_bset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_en && bit_set && reg_sel) |=> dir == ($past(dir) | $past(idx_mask)));

  // R9 R10
  dir_bclr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_en && !bit_set && bit_clr && reg_sel) |=> dir == ($past(dir) & ~$past(idx_mask)));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(wr_en || bit_set || bit_clr) |=> $stable(pad_oe));

  // R3
  od_rise_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pad_oe[OD_BIT]) |-> $past(wr_en || bit_set || bit_clr));
endmodule

bind gpio5_port gpio5_port_chk #(
  .BUS_W(BUS_W), .PORT_W(PORT_W), .OD_BIT(OD_BIT), .IDX_W($clog2(BUS_W))
) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .reg_sel     (reg_sel),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .bit_set     (bit_set),
  .bit_clr     (bit_clr),
  .bit_idx     (bit_idx),
  .rd_data     (rd_data),
  .pad_in      (pad_in),
  .pad_oe      (pad_oe),
  .tmr_clk_tap (tmr_clk_tap),
  .latch       (latch_q),
  .dir         (dir_q)
);

// File: tb/gpio5_port_test.sv
module gpio5_port_test;
  logic       clk;
  logic       rst_n;
  logic       reg_sel;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       bit_set;
  logic       bit_clr;
  logic [2:0] bit_idx;
  logic [7:0] rd_data;
  logic [4:0] pad_in;
  logic [4:0] pad_out;
  logic [4:0] pad_oe;
  logic       tmr_clk_tap;

  int n_tests = 0;
  int n_fail  = 0;

  gpio5_port uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .bit_set(bit_set), .bit_clr(bit_clr),
    .bit_idx(bit_idx), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .tmr_clk_tap(tmr_clk_tap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; wr_en = 1'b0; bit_set = 1'b0; bit_clr = 1'b0;
    reg_sel = 1'b0; wr_data = '0; bit_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bit_op(input logic sel, input logic set, input logic [2:0] idx);
    @(negedge clk);
    reg_sel = sel; bit_set = set; bit_clr = ~set; bit_idx = idx;
    @(negedge clk);
    bit_set = 1'b0; bit_clr = 1'b0;
  endtask

  task automatic set_pads(input logic [4:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    pad_in = 5'b00000;
    apply_reset();
    rd(1'b1, v);
    chk("R1 dir reset", v, 8'h1F);
    chk("R1 oe reset", {3'b0, pad_oe}, 8'h00);
    chk("R1 out reset", {3'b0, pad_out}, 8'h00);
  endtask

  task automatic t_read_pins();
    logic [7:0] v;
    apply_reset();
    bus_write(1'b0, 8'h0A);
    pad_in = 5'b10110;
    @(negedge clk);
    rd(1'b0, v);
    chk("R4 read lag one edge", v, 8'h00);
    chk("R11 tap lag one edge", {7'b0, tmr_clk_tap}, 8'h00);
    @(negedge clk);
    rd(1'b0, v);
    chk("R4 read pins not latch", v, 8'h16);
    chk("R11 tap after two edges", {7'b0, tmr_clk_tap}, 8'h01);
  endtask

  task automatic t_dir_write();
    logic [7:0] v;
    pad_in = 5'b00000;
    apply_reset();
    bus_write(1'b1, 8'hFF);
    rd(1'b1, v);
    chk("R5 upper dir bits zero", v, 8'h1F);
    bus_write(1'b1, 8'h0C);
    rd(1'b1, v);
    chk("R7 dir write", v, 8'h0C);
    chk("R2 R3 oe from dir", {3'b0, pad_oe}, 8'h13);
    chk("R7 latch untouched", {3'b0, pad_out}, 8'h00);
  endtask

  task automatic t_latch_write();
    logic [7:0] v;
    apply_reset();
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'hE5);
    chk("R6 R2 latch to pad_out", {3'b0, pad_out}, 8'h05);
    chk("R2 all outputs", {3'b0, pad_oe}, 8'h1F);
    rd(1'b1, v);
    chk("R6 dir untouched", v, 8'h00);
  endtask

  task automatic t_open_drain();
    apply_reset();
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h10);
    chk("R3 od released on latch 1 oe", {3'b0, pad_oe}, 8'h0F);
    chk("R3 od pad_out zero", {3'b0, pad_out}, 8'h00);
    bus_write(1'b0, 8'h00);
    chk("R3 od pulls low", {3'b0, pad_oe}, 8'h1F);
    bus_write(1'b1, 8'h10);
    chk("R3 od input released", {3'b0, pad_oe}, 8'h0F);
  endtask

  task automatic t_rmw();
    apply_reset();
    set_pads(5'b10101);
    bit_op(1'b0, 1'b1, 3'd1);
    chk("R8 bset copies pins", {3'b0, pad_out}, 8'h07);
    bus_write(1'b1, 8'h00);
    chk("R8 bit4 latch copied from pin", {3'b0, pad_oe}, 8'h0F);
    bit_op(1'b0, 1'b0, 3'd0);
    chk("R8 bclr on pins", {3'b0, pad_out}, 8'h04);
    set_pads(5'b01010);
    bit_op(1'b0, 1'b1, 3'd6);
    chk("R8 idx past port copies pins", {3'b0, pad_out}, 8'h0A);
    chk("R8 idx past port bit4", {3'b0, pad_oe}, 8'h1F);
  endtask

  task automatic t_dir_bits();
    logic [7:0] v;
    apply_reset();
    set_pads(5'b01111);
    bit_op(1'b1, 1'b0, 3'd2);
    rd(1'b1, v);
    chk("R9 dir bclr", v, 8'h1B);
    bit_op(1'b1, 1'b1, 3'd7);
    rd(1'b1, v);
    chk("R9 dir bset idx7 ignored", v, 8'h1B);
    bit_op(1'b1, 1'b0, 3'd5);
    rd(1'b1, v);
    chk("R9 dir bclr idx5 ignored", v, 8'h1B);
    bit_op(1'b1, 1'b1, 3'd2);
    rd(1'b1, v);
    chk("R9 dir bset", v, 8'h1F);
    chk("R9 latch untouched", {3'b0, pad_out}, 8'h00);
  endtask

  task automatic t_priority();
    apply_reset();
    set_pads(5'b00000);
    bus_write(1'b1, 8'h00);
    @(negedge clk);
    reg_sel = 1'b0; wr_en = 1'b1; wr_data = 8'h03; bit_set = 1'b1; bit_idx = 3'd4;
    @(negedge clk);
    wr_en = 1'b0; bit_set = 1'b0;
    chk("R10 write over bset", {3'b0, pad_out}, 8'h03);
    chk("R10 write over bset bit4", {3'b0, pad_oe}, 8'h1F);
    @(negedge clk);
    reg_sel = 1'b0; bit_set = 1'b1; bit_clr = 1'b1; bit_idx = 3'd2;
    @(negedge clk);
    bit_set = 1'b0; bit_clr = 1'b0;
    chk("R10 bset over bclr", {3'b0, pad_out}, 8'h04);
  endtask

  task automatic t_timer();
    apply_reset();
    bus_write(1'b1, 8'h00);
    pad_in = 5'b10000;
    @(negedge clk);
    chk("R11 tap rise one edge", {7'b0, tmr_clk_tap}, 8'h00);
    @(negedge clk);
    chk("R11 tap rise output mode", {7'b0, tmr_clk_tap}, 8'h01);
    pad_in = 5'b00000;
    @(negedge clk);
    chk("R11 tap fall one edge", {7'b0, tmr_clk_tap}, 8'h01);
    @(negedge clk);
    chk("R11 tap fall", {7'b0, tmr_clk_tap}, 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; wr_en = 1'b0; wr_data = '0;
    bit_set = 1'b0; bit_clr = 1'b0; bit_idx = '0; pad_in = '0;
    t_reset();
    t_read_pins();
    t_dir_write();
    t_latch_write();
    t_open_drain();
    t_rmw();
    t_dir_bits();
    t_priority();
    t_timer();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule